// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block buffers 18-bit words from a producer in one clock domain to a consumer in another. It is one direction of a bidirectional link. The storage holds 256 or 512 words, chosen by a parameter. Four active-low status flags report its state: empty, full, almost-empty and almost-full. Each flag is registered in the clock domain of the side that acts on it. Empty and almost-empty belong to the read clock. Full and almost-full belong to the write clock.

The write side works like a stream. A word moves in on a write-clock rising edge when `wr_valid` is high and `full_n` is high, so `full_n` acts as the ready signal. A producer holds `wr_valid` and `wr_data` until it sees `full_n` high at an edge. The read side works the same way. The consumer raises `rd_ready`, and a word is taken on a read-clock edge when `empty_n` is high. The word then appears registered on `rd_data`, with `rd_valid` high for one cycle.

The two fill thresholds come from offset registers in the write domain. They are loaded through a single-cycle configuration strobe. Both offsets are treated as quasi-static. They are changed only while the FIFO is idle.

Top module: `dcfifo_flags`

## Requirements
- R1: Words leave in the order they were accepted, unchanged in all 18 bits. An accepted read (`rd_ready` and `empty_n` high at a read-clock edge) sets `rd_valid` high and loads `rd_data` at that same edge. `rd_valid` is low after any edge with no accepted read.
- R2: `empty_n` is low while no words are stored. A read request while `empty_n` is low is ignored: `rd_valid` stays low and no stored word is consumed.
- R3: `full_n` is low while DEPTH words are stored. A write while `full_n` is low is ignored, and that word never appears at the output.
- R4: `almost_empty_n` is low when the stored count is less than or equal to the almost-empty offset, and high when the count is above it. It is registered on the read clock.
- R5: `almost_full_n` is low when the stored count is greater than DEPTH minus the almost-full offset, and high otherwise. It is registered on the write clock.
- R6: Both offsets reset to 8. When `cfg_wr` is high at a write-clock edge, `cfg_val` is loaded into one offset. `cfg_sel` = 0 selects the almost-empty offset and `cfg_sel` = 1 selects the almost-full offset. Any value from 0 to DEPTH is accepted.
- R7: While `rst_n` is low, `empty_n` and `almost_empty_n` are low, `full_n` and `almost_full_n` are high, and `rd_valid` is low.
- R8: A change made by one side reaches the flags of the other side within four cycles of the destination clock. Until then those flags may be pessimistic but never optimistic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | 18 | Word offered by the producer |
| full_n | output | 1 | Low when full; doubles as write ready |
| almost_full_n | output | 1 | Low when count > DEPTH - almost-full offset |
| cfg_wr | input | 1 | Offset load strobe (write clock) |
| cfg_sel | input | 1 | 0: almost-empty offset, 1: almost-full offset |
| cfg_val | input | $clog2(DEPTH)+1 | Offset value to load |
| rd_ready | input | 1 | Consumer requests a word |
| rd_valid | output | 1 | `rd_data` holds a freshly read word |
| rd_data | output | 18 | Registered read word |
| empty_n | output | 1 | Low when empty (read clock) |
| almost_empty_n | output | 1 | Low when count <= almost-empty offset |

## Verification
On every edge, assertions check that neither pointer moves while its blocking flag is low, and that each synchronised pointer changes by at most one Gray bit. They also check that the count seen in either domain never goes above DEPTH, that empty implies almost-empty, and that `rd_valid` follows only a non-empty cycle. Other properties are shown only by the bench scenarios. These include word ordering across the full range, the exact threshold edges for default and reloaded offsets, dropped writes at full, and the bound on flag latency after a single write or read.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int WORD_W      = 18;
  localparam int OFFSET_INIT = 8;

  typedef enum logic {
    OFS_EMPTY_SIDE = 1'b0,
    OFS_FULL_SIDE  = 1'b1
  } ofs_sel_e;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [PW-1:0] cfg_val,
  input  logic [PW-1:0] rgray_s,
  output logic          full_n,
  output logic          almost_full_n,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] ae_ofs
);
  logic [PW-1:0] wbin, wbin_nx, wgray_nx, rbin_s, wcnt_nx, af_ofs;
  logic [PW:0]   af_sum;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign wr_fire  = wr_valid & full_n;
  assign wbin_nx  = wbin + PW'(wr_fire);
  assign wgray_nx = (wbin_nx >> 1) ^ wbin_nx;
  assign rbin_s   = g2b(rgray_s);
  assign wcnt_nx  = wbin_nx - rbin_s;
  assign af_sum   = {1'b0, wcnt_nx} + {1'b0, af_ofs};
  assign wr_addr  = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin          <= '0;
      wgray         <= '0;
      full_n        <= 1'b1;
      almost_full_n <= 1'b1;
    end else begin
      wbin          <= wbin_nx;
      wgray         <= wgray_nx;
      full_n        <= (wgray_nx != {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
      almost_full_n <= !(af_sum > (PW+1)'(DEPTH));
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ae_ofs <= PW'(OFFSET_INIT);
      af_ofs <= PW'(OFFSET_INIT);
    end else if (cfg_wr) begin
      if (ofs_sel_e'(cfg_sel) == OFS_FULL_SIDE) af_ofs <= cfg_val;
      else                                      ae_ofs <= cfg_val;
    end
  end

  // R3: a full FIFO never advances its write pointer
  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |=> $stable(wbin));
  // R3: write-side occupancy never exceeds the storage
  p_cnt_bound_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    (wbin - rbin_s) <= PW'(DEPTH));
  // R8: the synchronised read pointer moves one Gray step at a time
  p_gray_step_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(rgray_s ^ $past(rgray_s)));
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_ready,
  input  logic [PW-1:0] wgray_s,
  input  logic [PW-1:0] ae_ofs,
  output logic          empty_n,
  output logic          almost_empty_n,
  output logic          rd_fire,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rgray
);
  logic [PW-1:0] rbin, rbin_nx, rgray_nx, wbin_s, rcnt_nx;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign rd_fire  = rd_ready & empty_n;
  assign rbin_nx  = rbin + PW'(rd_fire);
  assign rgray_nx = (rbin_nx >> 1) ^ rbin_nx;
  assign wbin_s   = g2b(wgray_s);
  assign rcnt_nx  = wbin_s - rbin_nx;
  assign rd_addr  = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin           <= '0;
      rgray          <= '0;
      empty_n        <= 1'b0;
      almost_empty_n <= 1'b0;
    end else begin
      rbin           <= rbin_nx;
      rgray          <= rgray_nx;
      empty_n        <= (rgray_nx != wgray_s);
      almost_empty_n <= (rcnt_nx > ae_ofs);
    end
  end

  // R2: an empty FIFO never advances its read pointer
  p_no_underflow_r2: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |=> $stable(rbin));
  // R4: empty always implies almost-empty
  p_empty_ae_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !almost_empty_n);
  // R4: read-side occupancy never exceeds the storage
  p_cnt_bound_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    (wbin_s - rbin) <= PW'(DEPTH));
  // R8: the synchronised write pointer moves one Gray step at a time
  p_gray_step_r8: assert property (@(posedge rclk) disable iff (!rst_n)
    $onehot0(wgray_s ^ $past(wgray_s)));
endmodule

// File: rtl/dcfifo_flags.sv
`timescale 1ns/1ps
module dcfifo_flags
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_data,
  output logic              full_n,
  output logic              almost_full_n,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [PW-1:0]     cfg_val,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty_n,
  output logic              almost_empty_n
);
  logic              wr_fire, rd_fire;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s, ae_ofs;
  logic [WORD_W-1:0] mem [DEPTH];

  dcf_wr_side #(.DEPTH(DEPTH)) u_wr (
    .wclk(wclk), .rst_n(rst_n), .wr_valid(wr_valid),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_val(cfg_val),
    .rgray_s(rgray_s), .full_n(full_n), .almost_full_n(almost_full_n),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wgray(wgray), .ae_ofs(ae_ofs)
  );

  dcf_rd_side #(.DEPTH(DEPTH)) u_rd (
    .rclk(rclk), .rst_n(rst_n), .rd_ready(rd_ready),
    .wgray_s(wgray_s), .ae_ofs(ae_ofs),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n),
    .rd_fire(rd_fire), .rd_addr(rd_addr), .rgray(rgray)
  );

  dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .din(wgray), .dout(wgray_s));
  dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .din(rgray), .dout(rgray_s));

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= mem[rd_addr];
    end
  end

  // R1: a valid read word only follows a non-empty request cycle
  p_valid_after_read_r1: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_valid |-> $past(empty_n && rd_ready));
  // R1: read data holds when no word is delivered
  p_data_hold_r1: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
endmodule

// File: tb/tb_dcfifo_flags.sv
`timescale 1ns/1ps
module tb_dcfifo_flags;
  localparam int DEPTH = 256;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_valid = 0, cfg_wr = 0, cfg_sel = 0, rd_ready = 0;
  logic [17:0] wr_data = '0;
  logic [PW-1:0] cfg_val = '0;
  logic full_n, almost_full_n, rd_valid, empty_n, almost_empty_n;
  logic [17:0] rd_data;

  int n_run = 0, n_fail = 0;
  int ae_o = 8, af_o = 8;
  logic [17:0] model_q[$];
  bit wdone;

  always #2 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dcfifo_flags #(.DEPTH(DEPTH)) dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .full_n(full_n),
    .almost_full_n(almost_full_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_val(cfg_val), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .empty_n(empty_n), .almost_empty_n(almost_empty_n)
  );

  function automatic bit exp_ae_n(int cnt, int ofs);
    return cnt > ofs;
  endfunction
  function automatic bit exp_af_n(int cnt, int ofs);
    return !(cnt > DEPTH - ofs);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [17:0] d);
    bit fn;
    @(negedge wclk);
    wr_valid = 1; wr_data = d; fn = full_n;
    @(negedge wclk);
    wr_valid = 0;
    if (fn) model_q.push_back(d);
  endtask

  task automatic do_read();
    bit en;
    logic [17:0] e;
    @(negedge rclk);
    rd_ready = 1; en = empty_n;
    @(negedge rclk);
    rd_ready = 0;
    if (en) begin
      if (model_q.size() == 0) chk("R1 spurious word", 1, 0);
      else begin
        e = model_q.pop_front();
        chk("R1 read data", int'(rd_data), int'(e));
      end
    end
    if (rd_valid != en) chk("R1/R2 rd_valid", int'(rd_valid), int'(en));
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic set_ofs(bit sel, int v);
    @(negedge wclk);
    cfg_wr = 1; cfg_sel = sel; cfg_val = PW'(v);
    @(negedge wclk);
    cfg_wr = 0;
    if (sel) af_o = v; else ae_o = v;
  endtask

  task automatic chk_flags(string req);
    int c = model_q.size();
    chk({req, " empty_n"}, int'(empty_n), int'(c != 0));
    chk({req, " full_n"}, int'(full_n), int'(c != DEPTH));
    chk({req, " almost_empty_n"}, int'(almost_empty_n), int'(exp_ae_n(c, ae_o)));
    chk({req, " almost_full_n"}, int'(almost_full_n), int'(exp_af_n(c, af_o)));
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge wclk);
    // R7: reset values
    chk("R7 empty_n", int'(empty_n), 0);
    chk("R7 almost_empty_n", int'(almost_empty_n), 0);
    chk("R7 full_n", int'(full_n), 1);
    chk("R7 almost_full_n", int'(almost_full_n), 1);
    chk("R7 rd_valid", int'(rd_valid), 0);
    rst_n = 1;
    settle();

    // R2: reads while empty are ignored
    repeat (3) do_read();
    chk("R2 rd_valid idle", int'(rd_valid), 0);
    chk("R2 data untouched", int'(rd_data), 0);

    // R8: one write reaches the read side within four read cycles
    do_write(18'h155AA);
    repeat (4) @(negedge rclk);
    chk("R8 empty_n latency", int'(empty_n), 1);
    repeat (7) do_write(18'($urandom));
    settle();
    chk_flags("R4 R6 default at 8");
    do_write(18'($urandom));
    settle();
    chk_flags("R4 above 8");

    // R5: almost-full edge at default offset
    while (model_q.size() < DEPTH - 8) do_write(18'($urandom));
    settle();
    chk_flags("R5 at DEPTH-8");
    do_write(18'($urandom));
    settle();
    chk_flags("R5 at DEPTH-7");
    while (model_q.size() < DEPTH) do_write(18'($urandom));
    settle();
    chk_flags("R3 full");
    do_write(18'h3ABCD); // dropped: model sees full_n low
    chk("R3 write dropped size", model_q.size(), DEPTH);

    // R1: drain in order; R8: read side change reaches write side
    do_read();
    repeat (4) @(negedge wclk);
    chk("R8 full_n latency", int'(full_n), 1);
    while (model_q.size() > 0) do_read();
    settle();
    chk_flags("R2 drained");
    do_read();

    // R6: reload offsets
    set_ofs(1'b0, 20);
    set_ofs(1'b1, 0);
    while (model_q.size() < 20) do_write(18'($urandom));
    settle();
    chk_flags("R6 ae=20 at 20");
    do_write(18'($urandom));
    settle();
    chk_flags("R6 ae=20 at 21");
    set_ofs(1'b1, DEPTH);
    settle();
    chk_flags("R6 af=DEPTH");
    while (model_q.size() < DEPTH) do_write(18'($urandom));
    set_ofs(1'b1, 0);
    settle();
    chk_flags("R5 af=0 full");
    while (model_q.size() > 0) do_read();
    set_ofs(1'b0, 8);
    set_ofs(1'b1, 8);

    // R1: concurrent random traffic
    wdone = 0;
    fork
      begin
        for (int i = 0; i < 1500; i++) begin
          repeat ($urandom_range(0, 2)) @(negedge wclk);
          do_write(18'($urandom));
        end
        wdone = 1;
      end
      begin
        while (!(wdone && model_q.size() == 0)) begin
          repeat ($urandom_range(0, 1)) @(negedge rclk);
          do_read();
        end
      end
    join
    settle();
    chk_flags("R1 after random");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule